// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Level Flag

This block is a first-in/first-out buffer for 9-bit words with a power-of-two depth set by the `DEPTH` parameter. A producer stores words and a consumer takes them with active-low strobes that are sampled on the system clock, so neither side supplies an address. Both sides walk a ring of storage locations. Each pointer carries one extra lap bit, which tells a full ring from an empty one.

Three active-low status outputs report the fill level: empty, full and more-than-half-full. A read attempted on an empty buffer, or a write attempted on a full one, has no effect. An active-low rewind input returns the read side to the first word stored since reset and leaves the write side where it is, so a block of data can be sent again. Read data is registered and is marked by a one-cycle valid pulse. A read strobe that arrives while the buffer is empty waits. If a write lands while that strobe is still held low, the new word flows straight through to the output.

Top module: `rtf_fifo`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both pointers are at location zero, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_vld` is 0.
- R2: `empty_n` is 0 exactly when no words are stored. A read strobe edge that arrives while the buffer is empty produces no `dout_vld` and does not move the read side.
- R3: `full_n` is 0 exactly when `DEPTH` words are stored. A write strobe edge that arrives while the buffer is full stores nothing and does not move the write side.
- R4: `half_n` is 0 exactly when more than `DEPTH/2` words are stored. It changes on the same clock edge as the write, read or rewind that crosses the threshold.
- R5: A high-to-low edge on `rt_n`, sampled while `wr_n` and `rd_n` are both high, moves the read side to location zero and leaves the write side unchanged. The flags then follow the new stored count, and the next read returns the first word written since reset. This holds when no more than `DEPTH` words have been written since reset.
- R6: A falling edge on `rt_n` that is sampled while `wr_n` or `rd_n` is low has no effect.
- R7: An operation commits on the clock edge that first samples its strobe low after it was sampled high. Holding a strobe low for further cycles starts no further operation.
- R8: Each accepted read drives the oldest stored word onto `dout` and raises `dout_vld` for exactly one cycle after the committing edge. Words leave in the order they were written.
- R9: A read and a write that commit on the same edge both take effect, and the stored count stays the same.
- R10: A read strobe that falls while the buffer is empty stays pending as long as `rd_n` is held low. One edge after a write commits, the pending read returns that word. `empty_n` is 1 for that single cycle and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind strobe |
| din | input | 9 | Word to store |
| dout | output | 9 | Registered read word |
| dout_vld | output | 1 | One-cycle pulse marking a new word on `dout` |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when `DEPTH` words are stored |
| half_n | output | 1 | Low when more than `DEPTH/2` words are stored |

## Verification
The bench builds the block with `DEPTH` set to 8. At that depth the half-level threshold is crossed on the fifth write and the buffer fills on the eighth, so the ignored write at full, a complete pointer lap and a rewind over a full buffer can all be reached in a few dozen cycles. Because the depth is small, a random stream of overlapping strobes wraps both pointers many times. This exercises the lap bit that separates the full and empty states at equal addresses.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

    localparam int WORD_W = 9;
    localparam int N_STRB = 3;
    localparam int IDX_WR = 0;
    localparam int IDX_RD = 1;
    localparam int IDX_RT = 2;

    typedef logic [WORD_W-1:0] word_t;

    // one-cycle falling-edge events of the three strobes
    typedef struct packed {
        logic rt;
        logic rd;
        logic wr;
    } strb_ev_t;

    function automatic bit pow2(input int v);
        return (v > 1) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rtf_fall.sv
module rtf_fall (
    input  logic clk,
    input  logic rst,
    input  logic n_in,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= n_in;
    end

    assign fall = prev_q & ~n_in;

endmodule

// File: rtl/rtf_store.sv
module rtf_store
    import rtf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata,
    output logic          rvld
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            rvld  <= 1'b0;
        end else begin
            rvld <= re;
            if (re) rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
    import rtf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  strb_ev_t      ev,
    input  logic          wr_lo,
    input  logic          rd_lo,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    logic [PW-1:0] wp_q, rp_q, wp_d, rp_d, cnt, cnt_d;
    logic          half_q, pend_q;
    logic          is_empty, is_full, rt_ok;

    assign cnt      = wp_q - rp_q;
    assign is_empty = (cnt == '0);
    assign is_full  = (cnt == PW'(DEPTH));

    assign wr_en = ev.wr && !is_full;
    assign rd_en = (ev.rd || pend_q) && rd_lo && !is_empty;
    assign rt_ok = ev.rt && !wr_lo && !rd_lo;

    always_comb begin
        wp_d = wp_q + (wr_en ? PW'(1) : PW'(0));
        if (rt_ok) rp_d = '0;
        else       rp_d = rp_q + (rd_en ? PW'(1) : PW'(0));
        cnt_d = wp_d - rp_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0;
            half_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            wp_q   <= wp_d;
            rp_q   <= rp_d;
            half_q <= (cnt_d > PW'(HALF));
            pend_q <= rd_lo && ((ev.rd && is_empty) || (pend_q && !rd_en));
        end
    end

    assign wr_addr = wp_q[AW-1:0];
    assign rd_addr = rp_q[AW-1:0];
    assign empty_n = !is_empty;
    assign full_n  = !is_full;
    assign half_n  = !half_q;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        is_full |=> (wp_q == $past(wp_q)))
        else $error("write side moved while full");

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        (is_empty && !rt_ok) |=> (rp_q == $past(rp_q)))
        else $error("read side moved while empty");

    p_rewind_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rt_ok |=> (rp_q == '0) && (wp_q == $past(wp_q)))
        else $error("rewind did not land on location zero");

    p_full_implies_half_r4: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !half_n)
        else $error("full without half flag");

    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n))
        else $error("empty and full together");

endmodule

// File: rtl/rtf_fifo.sv
module rtf_fifo
    import rtf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                rt_n,
    input  logic [WORD_W-1:0]   din,
    output logic [WORD_W-1:0]   dout,
    output logic                dout_vld,
    output logic                empty_n,
    output logic                full_n,
    output logic                half_n
);

    generate
        if (!pow2(DEPTH)) begin : g_bad_depth
            $error("DEPTH must be a power of two above one");
        end
    endgenerate

    logic [N_STRB-1:0] strb_n, fall;
    strb_ev_t          ev;
    logic              wr_en, rd_en;
    logic [AW-1:0]     wr_addr, rd_addr;

    assign strb_n[IDX_WR] = wr_n;
    assign strb_n[IDX_RD] = rd_n;
    assign strb_n[IDX_RT] = rt_n;

    for (genvar i = 0; i < N_STRB; i++) begin : g_edge
        rtf_fall u_fall (
            .clk  (clk),
            .rst  (rst),
            .n_in (strb_n[i]),
            .fall (fall[i])
        );
    end

    assign ev.wr = fall[IDX_WR];
    assign ev.rd = fall[IDX_RD];
    assign ev.rt = fall[IDX_RT];

    rtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .wr_lo   (!wr_n),
        .rd_lo   (!rd_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    rtf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (din),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (dout),
        .rvld  (dout_vld)
    );

    p_vld_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(!rd_n))
        else $error("output valid without read strobe");

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        dout_vld |=> !dout_vld)
        else $error("two reads from one strobe");

    p_empty_no_vld_r2: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && $stable(empty_n)) |=> !dout_vld)
        else $error("read returned data while empty");

endmodule

// File: tb/sim_rtf_fifo.sv
module sim_rtf_fifo;

    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_vld, empty_n, full_n, half_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rtf_fifo #(.DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    // behavioural reference
    logic [8:0] m_mem [D];
    int   m_wc, m_rc;
    bit   m_pend, m_pw, m_pr, m_pt;
    bit   e_vld;
    logic [8:0] e_dout;

    always @(posedge clk) begin
        int  c;
        bit  fw, fr, ft, wok, rok, tok;
        if (rst) begin
            m_wc = 0; m_rc = 0; m_pend = 0;
            m_pw = 1; m_pr = 1; m_pt = 1;
            e_vld = 0; e_dout = '0;
        end else begin
            c   = m_wc - m_rc;
            fw  = m_pw && !wr_n;
            fr  = m_pr && !rd_n;
            ft  = m_pt && !rt_n;
            wok = fw && (c < D);
            rok = (fr || m_pend) && !rd_n && (c > 0);
            tok = ft && wr_n && rd_n;
            e_vld = rok;
            if (rok) begin
                e_dout = m_mem[m_rc % D];
                m_rc++;
            end
            if (wok) begin
                m_mem[m_wc % D] = din;
                m_wc++;
            end
            if (tok) m_rc = 0;
            m_pend = !rd_n && ((fr && c == 0) || (m_pend && !rok));
            m_pw = wr_n; m_pr = rd_n; m_pt = rt_n;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 empty_n", {8'd0, empty_n}, {8'd0, (m_wc - m_rc) != 0});
            chk("R3 full_n",  {8'd0, full_n},  {8'd0, (m_wc - m_rc) != D});
            chk("R4 half_n",  {8'd0, half_n},  {8'd0, !((m_wc - m_rc) > D/2)});
            chk("R8 dout_vld", {8'd0, dout_vld}, {8'd0, e_vld});
            if (e_vld) chk("R8 dout", dout, e_dout);
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic put(input logic [8:0] d);
        wr_n = 1'b0; din = d; tick();
        wr_n = 1'b1; tick();
    endtask

    task automatic get();
        rd_n = 1'b0; tick();
        rd_n = 1'b1; tick();
    endtask

    task automatic do_reset();
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        rst = 1'b1; tick(); tick();
        rst = 1'b0; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        chk("R1 empty_n", {8'd0, empty_n}, 9'd0);
        chk("R1 full_n",  {8'd0, full_n},  9'd1);
        chk("R1 half_n",  {8'd0, half_n},  9'd1);
        chk("R1 dout_vld", {8'd0, dout_vld}, 9'd0);

        // R2 read on empty is ignored
        rd_n = 1'b0; tick();
        chk("R2 no vld on empty", {8'd0, dout_vld}, 9'd0);
        rd_n = 1'b1; tick();

        // fill: R4 threshold and R3 full
        for (int i = 0; i < D; i++) begin
            put(9'h100 + 9'(i));
            if (i == D/2 - 1) chk("R4 at half", {8'd0, half_n}, 9'd1);
            if (i == D/2)     chk("R4 above half", {8'd0, half_n}, 9'd0);
        end
        chk("R3 full after DEPTH writes", {8'd0, full_n}, 9'd0);
        put(9'h1FF);
        chk("R3 write ignored when full", {8'd0, full_n}, 9'd0);
        for (int i = 0; i < D; i++) begin
            rd_n = 1'b0; tick();
            chk("R3 R8 order", dout, 9'h100 + 9'(i));
            rd_n = 1'b1; tick();
        end
        chk("R3 drained exactly DEPTH", {8'd0, empty_n}, 9'd0);

        // R5 rewind after full drain
        rt_n = 1'b0; tick(); rt_n = 1'b1; tick();
        chk("R5 full after rewind", {8'd0, full_n}, 9'd0);
        rd_n = 1'b0; tick();
        chk("R5 first word again", dout, 9'h100);
        rd_n = 1'b1; tick();

        // R6 rewind ignored while a strobe is low
        do_reset();
        put(9'h011); put(9'h022); put(9'h033);
        get();
        rd_n = 1'b0; tick(); tick();
        rt_n = 1'b0; tick(); rt_n = 1'b1; tick();
        rd_n = 1'b1; tick();
        rd_n = 1'b0; tick();
        chk("R6 rewind ignored", dout, 9'h033);
        rd_n = 1'b1; tick();
        chk("R6 empty after", {8'd0, empty_n}, 9'd0);

        // R7 held write stores one word
        wr_n = 1'b0; din = 9'h0AA;
        repeat (4) tick();
        wr_n = 1'b1; tick();
        get();
        chk("R7 one op per strobe", {8'd0, empty_n}, 9'd0);

        // R9 simultaneous read and write
        put(9'h051); put(9'h052);
        wr_n = 1'b0; rd_n = 1'b0; din = 9'h053; tick();
        chk("R9 read side", dout, 9'h051);
        chk("R9 count kept", {8'd0, empty_n}, 9'd1);
        wr_n = 1'b1; rd_n = 1'b1; tick();
        get(); get();
        chk("R9 both applied", {8'd0, empty_n}, 9'd0);

        // R10 read flow-through
        rd_n = 1'b0; tick(); tick();
        wr_n = 1'b0; din = 9'h1C3; tick();
        chk("R10 empty released", {8'd0, empty_n}, 9'd1);
        chk("R10 no vld yet", {8'd0, dout_vld}, 9'd0);
        wr_n = 1'b1; tick();
        chk("R10 vld", {8'd0, dout_vld}, 9'd1);
        chk("R10 data", dout, 9'h1C3);
        chk("R10 empty again", {8'd0, empty_n}, 9'd0);
        rd_n = 1'b1; tick();

        // random overlapping traffic, no rewind
        for (int k = 0; k < 1500; k++) begin
            wr_n = ($urandom % 3) != 0;
            rd_n = ($urandom % 3) != 0;
            din  = 9'($urandom);
            tick();
        end
        wr_n = 1'b1; rd_n = 1'b1; tick(); tick();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule